// File: doc/BRIEF.md
# Strobe-Latched Read-Only Memory

A 2048-word by 8-bit read-only memory whose read address is not taken from a free-running clock. It is taken from a strobe: an active-low chip-enable. The block samples the chip-enable and the active-low output-enable in its system clock domain and detects their high-to-low transitions. When chip-enable falls, the address present at that moment is held in an internal latch. Later address changes have no effect until chip-enable falls again. After a parameterised number of clock cycles the addressed word is ready. It is driven out only while chip-enable is low and output-enable is both low and armed by a falling edge.

The storage is a square bit matrix. The upper address bits choose a row, and the low four bits choose a column inside each data bit's group of columns. Bit b of the word at column c lives at row bit b*16+c. The contents come from a parameterised sparse image: a list of (address, data) entries with distinct addresses. Every location not listed in the image reads as zero, like a memory whose bits start at 0 and are set to 1 one by one.

The three-state output is modelled by two 8-bit ports. `drive_o` is the per-bit output-enable. `data_o` carries the word while driven and reads zero otherwise.

Top module: `strobe_rom`

## Requirements
- R1: A location listed in the image returns its listed byte on data_o when read.
- R2: A location not listed in the image returns 0x00 on data_o when read.
- R3: The address held is the value of addr_i at the first clock edge that samples ce_ni low after sampling it high. Later changes of addr_i do not alter the data until the next such edge, which captures a new address.
- R4: With ce_ni and oe_ni falling together, drive_o stays 0x00 up to and including edge READ_LAT after the capture edge. drive_o is 0xFF after edge READ_LAT+1.
- R5: After the first clock edge that samples ce_ni high, drive_o and data_o are 0x00.
- R6: After the first clock edge that samples oe_ni high, drive_o and data_o are 0x00, even with ce_ni low and a read complete.
- R7: When oe_ni returns low while ce_ni stays low after a completed read, the outputs stay off after the first edge that samples oe_ni low. After the second edge, drive_o is 0xFF with the same word.
- R8: During reset and until a read completes, drive_o and data_o are 0x00. drive_o is always either 0x00 or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 11 | Word address |
| ce_ni | input | 1 | Active-low chip enable; its falling edge captures the address |
| oe_ni | input | 1 | Active-low output enable; its falling edge arms the outputs |
| data_o | output | 8 | Read word while driven, 0x00 otherwise |
| drive_o | output | 8 | Per-bit output enable, 0xFF while driving |

## Verification
A wrong latched address shows as a wrong byte on data_o at the first driven cycle of a read. This is READ_LAT+2 edges after chip-enable is sampled low. A sweep over all 2048 addresses, with the address changed right after capture, therefore exposes any wrong row or column decode and any leak of a later address. A wrong ready counter or a wrong arming flag shows as drive_o rising one edge early or late, or failing to drop one edge after a strobe is sampled high. The bench samples that edge exactly.

// File: rtl/strobe_rom_pkg.sv
package strobe_rom_pkg;
  typedef struct packed {
    logic lvl;   // synchronised level (1 = inactive)
    logic fall;  // high-to-low transition seen this cycle
  } strobe_t;

  function automatic int lat_clamp(int lat);
    return (lat < 1) ? 1 : lat;
  endfunction
endpackage

// File: rtl/strobe_rom_edge.sv
module strobe_rom_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_sense
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= sig_i[i];
        s2_q <= s1_q;
      end
    end
    assign lvl_o[i]  = s1_q;
    assign fall_o[i] = s2_q & ~s1_q;
  end
endmodule

// File: rtl/strobe_rom_capture.sv
module strobe_rom_capture
  import strobe_rom_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int READ_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  strobe_t           ce_i,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic              ready_o
);
  localparam int LAT_EFF = lat_clamp(READ_LAT);
  localparam int CNT_W   = $clog2(LAT_EFF + 1);

  logic [ADDR_W-1:0] addr_s_q, lat_addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ready_q;

  // addr_s_q is aligned with the strobe sample so capture uses the address of that edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_s_q   <= '0;
      lat_addr_q <= '0;
      cnt_q      <= '0;
      ready_q    <= 1'b0;
    end else begin
      addr_s_q <= addr_i;
      if (ce_i.fall) begin
        lat_addr_q <= addr_s_q;
        cnt_q      <= CNT_W'(LAT_EFF);
        ready_q    <= 1'b0;
      end else if (ce_i.lvl) begin
        cnt_q   <= '0;
        ready_q <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) ready_q <= 1'b1;
      end
    end
  end

  assign lat_addr_o = lat_addr_q;
  assign ready_o    = ready_q;

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i.fall |=> $stable(lat_addr_q));
  p_addr_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i.fall |=> lat_addr_q == $past(addr_i, 2));
  p_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i.fall |=> !ready_q);
endmodule

// File: rtl/strobe_rom_matrix.sv
module strobe_rom_matrix #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int COL_W   = 4,
  parameter int NUM_ENT = 4,
  parameter logic [NUM_ENT*ADDR_W-1:0] ENT_ADDR = '0,
  parameter logic [NUM_ENT*DATA_W-1:0] ENT_DATA = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;
  localparam int LINE_W = DATA_W * COLS;

  // Bit b of the word in column c sits at line bit b*COLS+c
  function automatic logic [LINE_W-1:0] line_init(int r);
    logic [LINE_W-1:0] l;
    logic [ADDR_W-1:0] a;
    l = '0;
    for (int e = 0; e < NUM_ENT; e++) begin
      a = ENT_ADDR[e*ADDR_W +: ADDR_W];
      if (a[ADDR_W-1:COL_W] == ROW_W'(r)) begin
        for (int b = 0; b < DATA_W; b++) begin
          if (ENT_DATA[e*DATA_W + b]) l[b*COLS + int'(a[COL_W-1:0])] = 1'b1;
        end
      end
    end
    return l;
  endfunction

  logic [LINE_W-1:0] lines [ROWS];
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign lines[r] = line_init(r);
  end

  logic [LINE_W-1:0] row_q;
  logic [COL_W-1:0]  col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= lines[addr_i[ADDR_W-1:COL_W]];
      col_q <= addr_i[COL_W-1:0];
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_col
    assign word_o[b] = row_q[b*COLS + int'(col_q)];
  end
endmodule

// File: rtl/strobe_rom_gate.sv
module strobe_rom_gate
  import strobe_rom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_lvl_i,
  input  strobe_t           oe_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] drive_o
);
  logic arm_q, drive_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= oe_i.fall | (arm_q & ~oe_i.lvl);
  end

  assign drive_en = arm_q & ~oe_i.lvl & ~ce_lvl_i & ready_i;
  assign drive_o  = {DATA_W{drive_en}};
  assign data_o   = drive_en ? word_i : '0;

  p_arm_needs_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_q) |-> $past(oe_i.fall));
endmodule

// File: rtl/strobe_rom.sv
module strobe_rom
  import strobe_rom_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 4,
  parameter int READ_LAT = 2,
  parameter int NUM_ENT  = 4,
  parameter logic [NUM_ENT*ADDR_W-1:0] ENT_ADDR = {11'h7FF, 11'h123, 11'h010, 11'h000},
  parameter logic [NUM_ENT*DATA_W-1:0] ENT_DATA = {8'h81, 8'h3C, 8'hA5, 8'h01}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] drive_o
);
  logic [1:0]        lvl, fall;
  strobe_t           ce_s, oe_s;
  logic [ADDR_W-1:0] lat_addr;
  logic              ready;
  logic [DATA_W-1:0] word;

  strobe_rom_edge #(.N(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({oe_ni, ce_ni}),
    .lvl_o (lvl),
    .fall_o(fall)
  );

  assign ce_s = '{lvl: lvl[0], fall: fall[0]};
  assign oe_s = '{lvl: lvl[1], fall: fall[1]};

  strobe_rom_capture #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .ce_i      (ce_s),
    .lat_addr_o(lat_addr),
    .ready_o   (ready)
  );

  strobe_rom_matrix #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W),
    .NUM_ENT(NUM_ENT), .ENT_ADDR(ENT_ADDR), .ENT_DATA(ENT_DATA)
  ) u_matrix (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(lat_addr),
    .word_o(word)
  );

  strobe_rom_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_lvl_i(ce_s.lvl),
    .oe_i    (oe_s),
    .ready_i (ready),
    .word_i  (word),
    .data_o  (data_o),
    .drive_o (drive_o)
  );

  p_ce_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce_ni) |-> (drive_o == '0) && (data_o == '0));
  p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oe_ni) |-> (drive_o == '0) && (data_o == '0));
  p_drive_whole_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o == '0) || (drive_o == '1));
endmodule

// File: tb/strobe_rom_bench.sv
module strobe_rom_bench;
  localparam int AW = 11, DW = 8, LAT = 3, NE = 12;

  function automatic logic [AW-1:0] ent_a(int k);
    if (k == 0) return '0;
    if (k == NE - 1) return '1;
    return AW'((k * 171 + 3) % 2048);
  endfunction
  function automatic logic [DW-1:0] ent_d(int k);
    return DW'((k * 37 + 90) % 256) | 8'h01;
  endfunction
  function automatic logic [NE*AW-1:0] pack_a();
    logic [NE*AW-1:0] v;
    for (int k = 0; k < NE; k++) v[k*AW +: AW] = ent_a(k);
    return v;
  endfunction
  function automatic logic [NE*DW-1:0] pack_d();
    logic [NE*DW-1:0] v;
    for (int k = 0; k < NE; k++) v[k*DW +: DW] = ent_d(k);
    return v;
  endfunction
  function automatic logic [DW-1:0] expect_of(logic [AW-1:0] a);
    for (int k = 0; k < NE; k++) if (ent_a(k) == a) return ent_d(k);
    return '0;
  endfunction
  function automatic bit listed(logic [AW-1:0] a);
    for (int k = 0; k < NE; k++) if (ent_a(k) == a) return 1'b1;
    return 1'b0;
  endfunction

  localparam logic [NE*AW-1:0] EA = pack_a();
  localparam logic [NE*DW-1:0] ED = pack_d();

  logic          clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data, drv;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  strobe_rom #(
    .ADDR_W(AW), .DATA_W(DW), .COL_W(4), .READ_LAT(LAT),
    .NUM_ENT(NE), .ENT_ADDR(EA), .ENT_DATA(ED)
  ) u_strobe_rom (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .oe_ni(oe_n),
    .data_o(data), .drive_o(drv)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic off_chk(input string tag);
    chk(drv == '0 && data == '0, tag, drv | data, 8'h00);
  endtask

  // Full read with the address disturbed right after capture
  task automatic read_one(input logic [AW-1:0] a);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); addr = ~a;
    repeat (LAT) @(negedge clk);
    chk(drv == '0, "R4 before ready", drv, 8'h00);
    @(negedge clk);
    chk(drv == '1, "R4 drive on", drv, 8'hFF);
    if (listed(a)) chk(data == expect_of(a), "R1 listed word", data, expect_of(a));
    else           chk(data == 8'h00, "R2 unlisted word", data, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    off_chk("R5 ce high");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    off_chk("R8 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    off_chk("R8 after reset");

    for (int a = 0; a < 2048; a++) read_one(AW'(a));

    // Output enable held high while chip enable is low
    @(negedge clk); addr = ent_a(3); ce_n = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    off_chk("R6 oe high with ce low");
    oe_n = 1'b0;
    @(negedge clk);
    off_chk("R7 one edge after oe low");
    @(negedge clk);
    chk(drv == '1 && data == ent_d(3), "R7 drive after arm", data, ent_d(3));

    // Address change with no new chip-enable edge is ignored
    addr = ent_a(5);
    repeat (4) @(negedge clk);
    chk(data == ent_d(3), "R3 address change ignored", data, ent_d(3));

    // Toggle output enable mid-access
    oe_n = 1'b1;
    @(negedge clk);
    off_chk("R6 oe high mid access");
    oe_n = 1'b0;
    @(negedge clk);
    off_chk("R7 rearm one edge");
    @(negedge clk);
    chk(drv == '1 && data == ent_d(3), "R7 rearmed same word", data, ent_d(3));

    // New chip-enable edge captures the new address
    ce_n = 1'b1;
    @(negedge clk);
    off_chk("R5 ce high mid access");
    addr = ent_a(7); ce_n = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    chk(drv == '1 && data == ent_d(7), "R3 recapture", data, ent_d(7));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule